// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter

This block holds two independent 16-bit count units. Each unit is set up by one nibble of a shared 8-bit mode register. A unit can count machine-cycle strobes (timer use) or falling transitions on its own external count pin (event-counter use). A gate option lets a unit advance only while its gate pin is high. A 2-bit mode field gives each unit one of four shapes: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself from the high byte, or a split arrangement in which unit 0 becomes two separate 8-bit counters.

Software reaches the count bytes, the mode register and a sticky overflow-flag register over a simple byte-wide register bus. Writes are synchronous and reads are combinational. Each unit also has a run-enable input from the surrounding logic, and each overflow flag is driven straight out to the chip's interrupt logic.

Top module: `twin_timer`

## Requirements
- R1: After a synchronous reset, both counts, the mode register and both overflow flags read 0.
- R2: The register map is 8Ah = unit 0 low byte, 8Bh = unit 1 low byte, 8Ch = unit 0 high byte, 8Dh = unit 1 high byte, 89h = mode register, 88h = flag register (bit 0 = unit 0, bit 1 = unit 1). Every mapped register reads back what was last written to it, and any other address reads 0. Mode bits [7:4] configure unit 0 and bits [3:0] configure unit 1. Within each nibble, bit 3 is gate, bit 2 is external-count select and bits 1:0 are the mode.
- R3: In mode 01 the unit is a 16-bit counter. It steps from FFFFh to 0000h and sets its overflow flag on that step.
- R4: In mode 00 only low-byte bits 4:0 count, with their carry going into the 8-bit high byte. Low-byte bits 7:5 stay unchanged. The step from 1FFFh of the 13-bit value to 0 sets the overflow flag.
- R5: In mode 10 only the low byte counts. When it steps from FFh, it loads the high byte's value, the high byte stays unchanged, and the overflow flag sets.
- R6: With external-count select set, the unit takes one count on each strobe cycle whose pin sample is low when the sample on the previous strobe cycle was high. Pin changes between strobes are not counted.
- R7: With gate set, the unit advances only while its gate pin is high. With gate clear, the gate pin has no effect.
- R8: An overflow flag stays set until a write to the flag register with a 1 in that flag's bit. If an overflow and such a clear happen in the same cycle, the flag ends up set.
- R9: In mode 11, unit 0's low byte counts under unit 0's own enables and flag. Unit 0's high byte counts machine-cycle strobes while run enable 1 is high, and sets flag 1. A unit 1 placed in mode 11 holds its count.
- R10: A unit does not advance while its run enable is low. A write to either of a unit's count bytes takes priority in that cycle: the written value is stored and the unit does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Machine-cycle strobe, one per machine cycle |
| run_i | input | 2 | Run enable per unit |
| cnt_pin_i | input | 2 | External count pin per unit, assumed synchronous to clk |
| gate_pin_i | input | 2 | Gate pin per unit |
| bus_addr_i | input | 8 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational on address |
| ovf_o | output | 2 | Sticky overflow flag per unit |

## Verification
A wrong internal state here shows up at the ports on the next read of a count byte or the flag register. A mis-decoded mode shows as a wrong carry boundary: bits 7:5 of the low byte change, the high byte fails to load, or the unit counts when it should hold. Each such fault shows within one strobe of the boundary value. The edge detector's stored sample is the one internal state not directly visible. An error there shows as a count one too high or too low after a planned pin sequence, so the bench drives pin patterns that put a rising transition, a held level and a change between strobes in front of each falling sample.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

    localparam int UNITS  = 2;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int LOW13  = 5;

    localparam logic [BYTE_W-1:0] ADDR_FLAGS = 8'h88;
    localparam logic [BYTE_W-1:0] ADDR_MODE  = 8'h89;
    localparam logic [BYTE_W-1:0] ADDR_LO0   = 8'h8A;
    localparam logic [BYTE_W-1:0] ADDR_HI0   = 8'h8C;

    typedef enum logic [1:0] {
        TM_13B    = 2'b00,
        TM_16B    = 2'b01,
        TM_RELOAD = 2'b10,
        TM_SPLIT  = 2'b11
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext_sel;
        tmode_e mode;
    } unit_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } count_t;

    typedef struct packed {
        count_t cnt;
        logic   wrap;
    } step_t;

    function automatic unit_cfg_t cfg_of(input logic [BYTE_W-1:0] m, input int unit);
        return (unit == 0) ? unit_cfg_t'(m[7:4]) : unit_cfg_t'(m[3:0]);
    endfunction

    function automatic logic [BYTE_W:0] step8(input logic [BYTE_W-1:0] v);
        return {1'b0, v} + {{BYTE_W{1'b0}}, 1'b1};
    endfunction

    function automatic step_t advance(input count_t c, input tmode_e m);
        step_t                   r;
        logic [BYTE_W+LOW13:0]   s13;
        logic [CNT_W:0]          s16;
        logic [BYTE_W:0]         s8;
        r   = '{cnt: c, wrap: 1'b0};
        s13 = '0;
        s16 = '0;
        s8  = '0;
        case (m)
            TM_13B: begin
                s13 = {1'b0, c.hi, c.lo[LOW13-1:0]} + 14'd1;
                r.cnt.hi             = s13[BYTE_W+LOW13-1:LOW13];
                r.cnt.lo[LOW13-1:0]  = s13[LOW13-1:0];
                r.wrap               = s13[BYTE_W+LOW13];
            end
            TM_16B: begin
                s16 = {1'b0, c} + 17'd1;
                r.cnt  = s16[CNT_W-1:0];
                r.wrap = s16[CNT_W];
            end
            TM_RELOAD: begin
                s8 = step8(c.lo);
                r.cnt.lo = s8[BYTE_W] ? c.hi : s8[BYTE_W-1:0];
                r.wrap   = s8[BYTE_W];
            end
            default: begin
                s8 = step8(c.lo);
                r.cnt.lo = s8[BYTE_W-1:0];
                r.wrap   = s8[BYTE_W];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tc_event.sv
module tc_event
    import twin_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      run_i,
    input  logic      pin_i,
    input  logic      gate_pin_i,
    input  unit_cfg_t cfg_i,
    output logic      inc_o
);
    logic prev_q;
    logic fall;
    logic allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (tick_i) begin
            prev_q <= pin_i;
        end
    end

    always_comb begin
        fall    = tick_i & prev_q & ~pin_i;
        allowed = run_i & (~cfg_i.gate | gate_pin_i);
        inc_o   = allowed & (cfg_i.ext_sel ? fall : tick_i);
    end
endmodule

// File: rtl/tc_core.sv
module tc_core
    import twin_timer_pkg::*;
#(
    parameter bit CAN_SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  logic              inc_hi_i,
    input  unit_cfg_t         cfg_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output count_t            cnt_o,
    output logic              wrap_o,
    output logic              wrap_hi_o
);
    count_t          cnt_q;
    count_t          nxt;
    step_t           st;
    logic [BYTE_W:0] hi_s;

    always_comb begin
        nxt       = cnt_q;
        wrap_o    = 1'b0;
        wrap_hi_o = 1'b0;
        st        = advance(cnt_q, cfg_i.mode);
        hi_s      = step8(cnt_q.hi);
        if (cfg_i.mode == TM_SPLIT) begin
            if (CAN_SPLIT) begin
                if (inc_i) begin
                    nxt.lo = st.cnt.lo;
                    wrap_o = st.wrap;
                end
                if (inc_hi_i) begin
                    nxt.hi    = hi_s[BYTE_W-1:0];
                    wrap_hi_o = hi_s[BYTE_W];
                end
            end
        end else if (inc_i) begin
            nxt    = st.cnt;
            wrap_o = st.wrap;
        end
        if (wr_lo_i || wr_hi_i) begin
            nxt       = cnt_q;
            wrap_o    = 1'b0;
            wrap_hi_o = 1'b0;
            if (wr_lo_i) nxt.lo = wdata_i;
            if (wr_hi_i) nxt.hi = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/twin_timer.sv
module twin_timer
    import twin_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [UNITS-1:0]  run_i,
    input  logic [UNITS-1:0]  cnt_pin_i,
    input  logic [UNITS-1:0]  gate_pin_i,
    input  logic [BYTE_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic [UNITS-1:0]  ovf_o
);
    logic [BYTE_W-1:0] mode_q;
    logic [UNITS-1:0]  flags_q;
    logic [UNITS-1:0]  inc_w;
    logic [UNITS-1:0]  wrap_w;
    logic [UNITS-1:0]  wrap_hi_w;
    logic [UNITS-1:0]  set_flag;
    logic [UNITS-1:0]  clr_flag;
    logic              split0;
    count_t            cnt_w [UNITS];

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        unit_cfg_t cfg;
        logic      wr_lo;
        logic      wr_hi;
        logic      inc_hi;

        assign cfg    = cfg_of(mode_q, u);
        assign wr_lo  = bus_we_i && (bus_addr_i == ADDR_LO0 + BYTE_W'(u));
        assign wr_hi  = bus_we_i && (bus_addr_i == ADDR_HI0 + BYTE_W'(u));
        assign inc_hi = (u == 0) ? (tick_i & run_i[UNITS-1]) : 1'b0;

        tc_event u_evt (
            .clk        (clk),
            .rst        (rst),
            .tick_i     (tick_i),
            .run_i      (run_i[u]),
            .pin_i      (cnt_pin_i[u]),
            .gate_pin_i (gate_pin_i[u]),
            .cfg_i      (cfg),
            .inc_o      (inc_w[u])
        );

        tc_core #(.CAN_SPLIT(u == 0)) u_core (
            .clk       (clk),
            .rst       (rst),
            .inc_i     (inc_w[u]),
            .inc_hi_i  (inc_hi),
            .cfg_i     (cfg),
            .wr_lo_i   (wr_lo),
            .wr_hi_i   (wr_hi),
            .wdata_i   (bus_wdata_i),
            .cnt_o     (cnt_w[u]),
            .wrap_o    (wrap_w[u]),
            .wrap_hi_o (wrap_hi_w[u])
        );
    end

    always_comb begin
        split0      = (cfg_of(mode_q, 0).mode == TM_SPLIT);
        set_flag[0] = wrap_w[0];
        set_flag[1] = wrap_hi_w[0] | wrap_hi_w[1] | (wrap_w[1] & ~split0);
        clr_flag    = (bus_we_i && bus_addr_i == ADDR_FLAGS) ?
                      bus_wdata_i[UNITS-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            flags_q <= '0;
        end else begin
            if (bus_we_i && bus_addr_i == ADDR_MODE) mode_q <= bus_wdata_i;
            flags_q <= (flags_q & ~clr_flag) | set_flag;
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_FLAGS:     bus_rdata_o = {{(BYTE_W-UNITS){1'b0}}, flags_q};
            ADDR_MODE:      bus_rdata_o = mode_q;
            ADDR_LO0:       bus_rdata_o = cnt_w[0].lo;
            ADDR_LO0 + 8'd1: bus_rdata_o = cnt_w[1].lo;
            ADDR_HI0:       bus_rdata_o = cnt_w[0].hi;
            ADDR_HI0 + 8'd1: bus_rdata_o = cnt_w[1].hi;
            default:        bus_rdata_o = '0;
        endcase
    end

    assign ovf_o = flags_q;
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
    import twin_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [UNITS-1:0]  run_i,
    input logic [BYTE_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [BYTE_W-1:0] bus_wdata_i,
    input logic [UNITS-1:0]  ovf_o,
    input logic [BYTE_W-1:0] mode_q,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1,
    input logic [UNITS-1:0]  inc
);
    logic wr0;
    logic wr1;
    logic clr0;
    logic clr1;

    assign wr0  = bus_we_i && (bus_addr_i == ADDR_LO0 || bus_addr_i == ADDR_HI0);
    assign wr1  = bus_we_i && (bus_addr_i == ADDR_LO0 + 8'd1 || bus_addr_i == ADDR_HI0 + 8'd1);
    assign clr0 = bus_we_i && bus_addr_i == ADDR_FLAGS && bus_wdata_i[0];
    assign clr1 = bus_we_i && bus_addr_i == ADDR_FLAGS && bus_wdata_i[1];

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ovf_o == 2'b00 && mode_q == 8'h00 && cnt0 == 16'h0 && cnt1 == 16'h0));

    // R10
    a_r10_no_run: assert property (@(posedge clk) disable iff (rst)
        !run_i[0] |-> !inc[0]);

    // R10
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc[0] && !wr0 && mode_q[5:4] != 2'b11) |=> $stable(cnt0));

    // R3
    a_r3_wrap16: assert property (@(posedge clk) disable iff (rst)
        (mode_q[5:4] == 2'b01 && cnt0 == 16'hFFFF && inc[0] && !wr0)
        |=> (cnt0 == 16'h0000 && ovf_o[0]));

    // R5
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (mode_q[1:0] == 2'b10 && mode_q[5:4] != 2'b11 && cnt1[7:0] == 8'hFF && inc[1] && !wr1)
        |=> (cnt1[7:0] == $past(cnt1[15:8]) && ovf_o[1]));

    // R9
    a_r9_unit1_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_q[1:0] == 2'b11 && !wr1) |=> $stable(cnt1));

    // R8
    a_r8_sticky0: assert property (@(posedge clk) disable iff (rst)
        (ovf_o[0] && !clr0) |=> ovf_o[0]);

    // R8
    a_r8_sticky1: assert property (@(posedge clk) disable iff (rst)
        (ovf_o[1] && !clr1) |=> ovf_o[1]);
endmodule

bind twin_timer twin_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .ovf_o       (ovf_o),
    .mode_q      (mode_q),
    .cnt0        (cnt_w[0]),
    .cnt1        (cnt_w[1]),
    .inc         (inc_w)
);

// File: tb/twin_timer_test.sv
module twin_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [1:0] run_i = 2'b00;
    logic [1:0] cnt_pin_i = 2'b00;
    logic [1:0] gate_pin_i = 2'b00;
    logic [7:0] bus_addr_i = 8'h00;
    logic       bus_we_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic [1:0] ovf_o;

    int tests = 0;
    int fails = 0;

    localparam logic [7:0] A_FLG = 8'h88, A_MOD = 8'h89;
    localparam logic [7:0] A_L0 = 8'h8A, A_L1 = 8'h8B, A_H0 = 8'h8C, A_H1 = 8'h8D;

    twin_timer uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i),
        .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i),
        .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .ovf_o(ovf_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        bus_addr_i = a;
        #1;
        check(tag, bus_rdata_o, exp);
    endtask

    task automatic expect_ovf(input logic [1:0] exp, input string tag);
        #1;
        check(tag, {6'b0, ovf_o}, {6'b0, exp});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset_and_map;
        expect_reg(A_L0, 8'h00, "R1 lo0");
        expect_reg(A_H1, 8'h00, "R1 hi1");
        expect_reg(A_MOD, 8'h00, "R1 mode");
        expect_ovf(2'b00, "R1 flags");
        wr(A_MOD, 8'hA5);
        expect_reg(A_MOD, 8'hA5, "R2 mode readback");
        wr(A_H1, 8'h3C);
        expect_reg(A_H1, 8'h3C, "R2 hi1 readback");
        expect_reg(8'h90, 8'h00, "R2 unmapped");
        wr(A_H1, 8'h00);
        wr(A_MOD, 8'h00);
    endtask

    task automatic t_mode16;
        wr(A_MOD, 8'h10);
        wr(A_L0, 8'hFE); wr(A_H0, 8'hFF);
        run_i = 2'b01;
        ticks(1);
        expect_reg(A_L0, 8'hFF, "R3 pre-wrap lo");
        expect_ovf(2'b00, "R3 no flag yet");
        ticks(1);
        expect_reg(A_L0, 8'h00, "R3 wrap lo");
        expect_reg(A_H0, 8'h00, "R3 wrap hi");
        expect_ovf(2'b01, "R3 flag set");
        ticks(1);
        expect_reg(A_L0, 8'h01, "R3 after wrap");
        expect_ovf(2'b01, "R8 flag sticky");
        wr(A_FLG, 8'h01);
        expect_ovf(2'b00, "R8 flag cleared");
    endtask

    task automatic t_set_wins;
        run_i = 2'b01;
        wr(A_L0, 8'hFF); wr(A_H0, 8'hFF);
        @(negedge clk);
        tick_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = A_FLG; bus_wdata_i = 8'h01;
        @(negedge clk);
        tick_i = 1'b0; bus_we_i = 1'b0;
        expect_ovf(2'b01, "R8 set beats clear");
        wr(A_FLG, 8'h03);
    endtask

    task automatic t_mode13;
        run_i = 2'b00;
        wr(A_MOD, 8'h00);
        wr(A_L0, 8'hFF); wr(A_H0, 8'h12);
        run_i = 2'b01;
        ticks(1);
        expect_reg(A_L0, 8'hE0, "R4 low5 carry keeps 7:5");
        expect_reg(A_H0, 8'h13, "R4 carry into hi");
        expect_ovf(2'b00, "R4 no flag");
        run_i = 2'b00;
        wr(A_L0, 8'h1F); wr(A_H0, 8'hFF);
        run_i = 2'b01;
        ticks(1);
        expect_reg(A_L0, 8'h00, "R4 wrap lo");
        expect_reg(A_H0, 8'h00, "R4 wrap hi");
        expect_ovf(2'b01, "R4 flag");
        wr(A_FLG, 8'h03);
        run_i = 2'b00;
    endtask

    task automatic t_reload;
        wr(A_MOD, 8'h02);
        wr(A_H1, 8'h80); wr(A_L1, 8'hFE);
        run_i = 2'b10;
        ticks(2);
        expect_reg(A_L1, 8'h80, "R5 reloaded");
        expect_reg(A_H1, 8'h80, "R5 hi kept");
        expect_ovf(2'b10, "R5 flag");
        ticks(1);
        expect_reg(A_L1, 8'h81, "R5 after reload");
        run_i = 2'b00;
        wr(A_FLG, 8'h03);
    endtask

    task automatic t_counter;
        wr(A_MOD, 8'h50);
        wr(A_L0, 8'h00); wr(A_H0, 8'h00);
        run_i = 2'b01;
        @(negedge clk); cnt_pin_i[0] = 1'b1; tick_i = 1'b1;
        @(negedge clk); cnt_pin_i[0] = 1'b0;
        @(negedge clk); cnt_pin_i[0] = 1'b0;
        @(negedge clk); cnt_pin_i[0] = 1'b1;
        @(negedge clk); cnt_pin_i[0] = 1'b0;
        @(negedge clk); tick_i = 1'b0;
        expect_reg(A_L0, 8'h02, "R6 two falls counted");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cnt_pin_i[0] = ~cnt_pin_i[0];
        end
        @(negedge clk);
        expect_reg(A_L0, 8'h02, "R6 no count between strobes");
        cnt_pin_i[0] = 1'b0;
        run_i = 2'b00;
    endtask

    task automatic t_gate_and_run;
        wr(A_MOD, 8'h90);
        wr(A_L0, 8'h00); wr(A_H0, 8'h00);
        run_i = 2'b01; gate_pin_i = 2'b00;
        ticks(5);
        expect_reg(A_L0, 8'h00, "R7 gate low blocks");
        gate_pin_i = 2'b01;
        ticks(3);
        expect_reg(A_L0, 8'h03, "R7 gate high counts");
        run_i = 2'b00;
        ticks(4);
        expect_reg(A_L0, 8'h03, "R10 run low holds");
        gate_pin_i = 2'b00;
    endtask

    task automatic t_write_priority;
        wr(A_MOD, 8'h10);
        wr(A_L0, 8'h10);
        run_i = 2'b01;
        @(negedge clk);
        tick_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = A_L0; bus_wdata_i = 8'h40;
        @(negedge clk);
        bus_we_i = 1'b0;
        expect_reg(A_L0, 8'h40, "R10 write beats count");
        @(negedge clk);
        tick_i = 1'b0;
        expect_reg(A_L0, 8'h41, "R10 counts after write");
        run_i = 2'b00;
    endtask

    task automatic t_split;
        wr(A_FLG, 8'h03);
        wr(A_MOD, 8'h33);
        wr(A_L0, 8'hFF); wr(A_H0, 8'hFE);
        wr(A_L1, 8'h05); wr(A_H1, 8'h07);
        run_i = 2'b11;
        ticks(1);
        expect_reg(A_L0, 8'h00, "R9 lo0 wraps");
        expect_reg(A_H0, 8'hFF, "R9 hi0 counts");
        expect_ovf(2'b01, "R9 flag0 from lo");
        ticks(1);
        expect_reg(A_L0, 8'h01, "R9 lo0 next");
        expect_reg(A_H0, 8'h00, "R9 hi0 wraps");
        expect_ovf(2'b11, "R9 flag1 from hi0");
        expect_reg(A_L1, 8'h05, "R9 unit1 lo held");
        expect_reg(A_H1, 8'h07, "R9 unit1 hi held");
        run_i = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_and_map();
        t_mode16();
        t_set_wins();
        t_mode13();
        t_reload();
        t_counter();
        t_gate_and_run();
        t_write_priority();
        t_split();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule